// File: doc/BRIEF.md
# Codec Sample FIFO and Status Monitor

This block sits between a host data port and the two converter paths of a stereo audio codec. The playback side keeps a small queue of stereo words that the host writes and the converter consumes, one word per sample tick. The capture side keeps a small queue that the converter fills on each sample tick and the host reads. For each sample period the block records whether the capture queue had to refuse a new word and whether the playback queue had nothing to give. It also keeps a combined error bit, a data-request bit, and a calibration-busy bit that stays set for a fixed number of sample periods after the host leaves mode-change-enable.

The calibration-busy tracker is a three-state machine. `CB_IDLE` moves to `CB_MODECHG` when `mode_chg` is high. `CB_MODECHG` moves to `CB_SETTLE` when `mode_chg` goes low. `CB_SETTLE` counts sample ticks. It returns to `CB_IDLE` on the tick that completes the hold count, and goes back to `CB_MODECHG` if `mode_chg` rises again. The busy bit is high only in `CB_SETTLE`.

All queue decisions within a cycle use the occupancy held at the start of that cycle. The status byte is registered, so it shows the flags and occupancy from the cycle before.

Top module: `codec_fifo_status`

## Requirements
- R1: On a `sample_tick` with fewer than 16 words held, the capture queue stores `adc_sample`. A `cap_pop` with at least one word held loads the oldest word onto `cap_data` one cycle later.
- R2: On a `sample_tick` with 16 capture words already held, the new word is discarded and the stored words stay as they were. The capture-overrun flag (status bit 0) then reads 1 until the next tick, and that next tick sets it to 0 if it found space.
- R3: On a `sample_tick` with the playback queue not empty, the oldest word is removed and appears on `dac_sample` one cycle later.
- R4: On a `sample_tick` with the playback queue empty, the playback-underrun flag (status bit 1) is set. Every tick rewrites this flag.
- R5: On a playback underrun, `dac_sample` becomes all zeros (mid-scale, two's complement) when `zero_sel` or `basic_mode` is 1. When both are 0, it keeps the previous word.
- R6: Status bit 2 equals the OR of status bits 0 and 1.
- R7: `pb_req` is 1 while fewer than 16 playback words are held. `cap_req` is 1 while at least one capture word is held. Status bit 3 is the OR of the two.
- R8: Status bit 4 (calibration busy) is 1 from the cycle after `mode_chg` falls until 128 sample ticks have occurred. If `mode_chg` rises during the window, the bit clears and a full new window starts when `mode_chg` falls again.
- R9: Reset clears the status byte, `dac_sample` and `cap_data` to zero. The status byte reflects the state of the previous cycle, and bits 7:5 always read 0.
- R10: A `cap_pop` while the capture queue is empty leaves `cap_data` unchanged and sets no flag.
- R11: A `pb_push` while 16 playback words are held is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-cycle strobe, once per sample period |
| adc_sample | input | 32 | Captured stereo word {left, right} |
| cap_pop | input | 1 | Host read of the capture queue |
| cap_data | output | 32 | Last word read from the capture queue |
| pb_push | input | 1 | Host write to the playback queue |
| pb_data | input | 32 | Playback stereo word to write |
| dac_sample | output | 32 | Word sent to the converters |
| zero_sel | input | 1 | On underrun, output mid-scale instead of repeating the last word |
| basic_mode | input | 1 | Basic mode; forces mid-scale on underrun |
| mode_chg | input | 1 | Mode-change-enable from the host |
| pb_req | output | 1 | Playback queue has free space |
| cap_req | output | 1 | Capture queue holds data |
| status | output | 8 | Read-only status byte |

## Verification
Two situations are hard to reach from the ports. The first is a full 128-tick calibration window followed by a window that `mode_chg` cuts short and restarts. The stimulus holds `mode_chg` for a few cycles, then runs about 150 ticks so the window can run out. It then raises `mode_chg` again partway through a second window. The second is a capture overrun on the exact tick that finds the queue full. To reach it, the bench stops all host reads while the ticks continue well past 16 words. In the same way, it fills the playback queue past 16 words and then starves it under each combination of `zero_sel` and `basic_mode`.

// File: rtl/codec_stat_pkg.sv
package codec_stat_pkg;

    typedef enum logic [1:0] {
        CB_IDLE    = 2'd0,
        CB_MODECHG = 2'd1,
        CB_SETTLE  = 2'd2
    } cal_state_e;

    localparam int STAT_OVR  = 0;
    localparam int STAT_UND  = 1;
    localparam int STAT_SUM  = 2;
    localparam int STAT_DREQ = 3;
    localparam int STAT_BUSY = 4;

endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R11
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R1
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> !empty);

endmodule

// File: rtl/cap_path.sv
module cap_path #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] adc_in,
    input  logic             host_pop,
    output logic [WIDTH-1:0] rdata,
    output logic             ovr,
    output logic             req
);
    logic [WIDTH-1:0] head;
    logic             full, empty;

    sample_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (strobe),
        .din   (adc_in),
        .pop   (host_pop),
        .head  (head),
        .full  (full),
        .empty (empty)
    );

    assign req = !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            ovr   <= 1'b0;
        end else begin
            if (host_pop && !empty) rdata <= head;
            if (strobe)             ovr   <= full;
        end
    end

    // R2
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && full) |=> ovr);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && empty) |=> $stable(rdata));

endmodule

// File: rtl/play_path.sv
module play_path #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             host_push,
    input  logic [WIDTH-1:0] host_din,
    input  logic             zero_sel,
    input  logic             basic_mode,
    output logic [WIDTH-1:0] dac_out,
    output logic             und,
    output logic             req
);
    localparam logic [WIDTH-1:0] MIDSCALE = '0;

    logic [WIDTH-1:0] head;
    logic             full, empty;
    logic             fill_mid;

    sample_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (host_push),
        .din   (host_din),
        .pop   (strobe),
        .head  (head),
        .full  (full),
        .empty (empty)
    );

    assign req      = !full;
    assign fill_mid = zero_sel || basic_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_out <= '0;
            und     <= 1'b0;
        end else if (strobe) begin
            und <= empty;
            if (!empty)        dac_out <= head;
            else if (fill_mid) dac_out <= MIDSCALE;
        end
    end

    // R4
    underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && empty) |=> und);

    // R5
    basic_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && empty && basic_mode) |=> (dac_out == '0));

    // R5
    hold_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && empty && !zero_sel && !basic_mode) |=> $stable(dac_out));

endmodule

// File: rtl/cal_busy_fsm.sv
module cal_busy_fsm
    import codec_stat_pkg::*;
#(
    parameter int HOLD_SAMPLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mce,
    input  logic strobe,
    output logic busy
);
    localparam int CNT_W = (HOLD_SAMPLES > 1) ? $clog2(HOLD_SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_SAMPLES - 1);

    cal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             window_done;

    assign window_done = strobe && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CB_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != CB_SETTLE)  cnt_q <= '0;
            else if (strobe)           cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CB_IDLE:    if (mce) state_d = CB_MODECHG;
            CB_MODECHG: if (!mce) state_d = CB_SETTLE;
            CB_SETTLE: begin
                if (mce)              state_d = CB_MODECHG;
                else if (window_done) state_d = CB_IDLE;
            end
            default:    state_d = CB_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == CB_SETTLE);
    end

    // R8
    hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mce && !strobe) |=> busy);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mce |=> !busy);

endmodule

// File: rtl/codec_fifo_status.sv
module codec_fifo_status
    import codec_stat_pkg::*;
#(
    parameter int CH_W         = 16,
    parameter int FIFO_DEPTH   = 16,
    parameter int HOLD_SAMPLES = 128,
    parameter int STAT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic [2*CH_W-1:0] adc_sample,
    input  logic              cap_pop,
    output logic [2*CH_W-1:0] cap_data,
    input  logic              pb_push,
    input  logic [2*CH_W-1:0] pb_data,
    output logic [2*CH_W-1:0] dac_sample,
    input  logic              zero_sel,
    input  logic              basic_mode,
    input  logic              mode_chg,
    output logic              pb_req,
    output logic              cap_req,
    output logic [STAT_W-1:0] status
);
    localparam int SW = 2 * CH_W;

    logic              ovr, und, busy;
    logic [STAT_W-1:0] stat_d;

    cap_path #(.WIDTH(SW), .DEPTH(FIFO_DEPTH)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (sample_tick),
        .adc_in   (adc_sample),
        .host_pop (cap_pop),
        .rdata    (cap_data),
        .ovr      (ovr),
        .req      (cap_req)
    );

    play_path #(.WIDTH(SW), .DEPTH(FIFO_DEPTH)) u_play (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (sample_tick),
        .host_push  (pb_push),
        .host_din   (pb_data),
        .zero_sel   (zero_sel),
        .basic_mode (basic_mode),
        .dac_out    (dac_sample),
        .und        (und),
        .req        (pb_req)
    );

    cal_busy_fsm #(.HOLD_SAMPLES(HOLD_SAMPLES)) u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .mce    (mode_chg),
        .strobe (sample_tick),
        .busy   (busy)
    );

    always_comb begin
        stat_d            = '0;
        stat_d[STAT_OVR]  = ovr;
        stat_d[STAT_UND]  = und;
        stat_d[STAT_SUM]  = ovr || und;
        stat_d[STAT_DREQ] = pb_req || cap_req;
        stat_d[STAT_BUSY] = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= stat_d;
    end

    // R6
    sum_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_SUM] == (status[STAT_OVR] || status[STAT_UND]));

    // R7
    dreq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_req || cap_req) |=> status[STAT_DREQ]);

endmodule

// File: tb/sim_codec_fifo_status.sv
module sim_codec_fifo_status;
    localparam int D = 16;
    localparam int HOLD = 128;
    localparam int MAX_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_tick = 1'b0;
    logic [31:0] adc_sample = '0;
    logic        cap_pop = 1'b0;
    logic [31:0] cap_data;
    logic        pb_push = 1'b0;
    logic [31:0] pb_data = '0;
    logic [31:0] dac_sample;
    logic        zero_sel = 1'b0;
    logic        basic_mode = 1'b0;
    logic        mode_chg = 1'b0;
    logic        pb_req, cap_req;
    logic [7:0]  status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    codec_fifo_status u0 (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .adc_sample(adc_sample), .cap_pop(cap_pop), .cap_data(cap_data),
        .pb_push(pb_push), .pb_data(pb_data), .dac_sample(dac_sample),
        .zero_sel(zero_sel), .basic_mode(basic_mode), .mode_chg(mode_chg),
        .pb_req(pb_req), .cap_req(cap_req), .status(status)
    );

    // behavioural reference
    logic [31:0] pbq[$];
    logic [31:0] cq[$];
    logic [31:0] m_dac, m_cap;
    logic [7:0]  m_stat;
    bit          m_ovr, m_und;
    int          cal_st, cal_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            pbq.delete(); cq.delete();
            m_dac = '0; m_cap = '0; m_stat = '0;
            m_ovr = 0; m_und = 0; cal_st = 0; cal_cnt = 0;
        end else begin
            int pbn, cn;
            pbn = pbq.size();
            cn  = cq.size();
            m_stat = {3'b000, cal_st == 2, (pbn < D) || (cn > 0),
                      m_ovr | m_und, m_und, m_ovr};
            if (cap_pop && cn > 0) m_cap = cq.pop_front();
            if (sample_tick) begin
                m_ovr = (cn == D);
                if (cn < D) cq.push_back(adc_sample);
                m_und = (pbn == 0);
                if (pbn > 0) m_dac = pbq.pop_front();
                else if (zero_sel || basic_mode) m_dac = '0;
            end
            if (pb_push && pbn < D) pbq.push_back(pb_data); // R11 drop when full
            case (cal_st)
                0: if (mode_chg) cal_st = 1;
                1: if (!mode_chg) begin cal_st = 2; cal_cnt = 0; end
                default: begin
                    if (mode_chg) cal_st = 1;
                    else if (sample_tick) begin
                        if (cal_cnt == HOLD - 1) cal_st = 0;
                        cal_cnt++;
                    end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1/R10 cap_data", cap_data, m_cap);
        chk("R3/R5 dac_sample", dac_sample, m_dac);
        chk("R2 overrun bit", 32'(status[0]), 32'(m_stat[0]));
        chk("R4 underrun bit", 32'(status[1]), 32'(m_stat[1]));
        chk("R6 summary bit", 32'(status[2]), 32'(m_stat[2]));
        chk("R7 dreq bit", 32'(status[3]), 32'(m_stat[3]));
        chk("R8 busy bit", 32'(status[4]), 32'(m_stat[4]));
        chk("R9 upper bits", 32'(status[7:5]), 32'(m_stat[7:5]));
        chk("R7 pb_req", 32'(pb_req), 32'(pbq.size() < D));
        chk("R7 cap_req", 32'(cap_req), 32'(cq.size() > 0));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input int te, input int p_pop, input int p_push);
        for (int i = 0; i < n; i++) begin
            sample_tick = (te != 0) && (i % te == 0);
            adc_sample  = $urandom;
            pb_data     = $urandom;
            cap_pop     = ($urandom % 100) < p_pop;
            pb_push     = ($urandom % 100) < p_push;
            cyc();
        end
        sample_tick = 0; cap_pop = 0; pb_push = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(MAX_CYC * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(); // R9 reset state
        chk("R9 reset status", 32'(status), 32'h0);
        rst_n = 1'b1;
        run(400, 3, 40, 40);
        run(40, 2, 0, 50);             // R2 capture fills and overruns
        run(40, 0, 100, 0);            // R10 drain then pop empty
        run(30, 0, 0, 100);            // R11 overfill playback
        run(60, 2, 0, 0);              // R4/R5 starve, hold last word
        zero_sel = 1; run(10, 2, 0, 0);
        zero_sel = 0;
        run(6, 0, 0, 100);
        run(16, 2, 0, 0);
        basic_mode = 1;
        run(6, 0, 0, 100);
        run(16, 2, 0, 0);
        basic_mode = 0;
        mode_chg = 1; run(5, 2, 30, 30);   // R8 full window
        mode_chg = 0; run(300, 2, 30, 30);
        mode_chg = 1; run(3, 2, 30, 30);   // R8 restart window
        mode_chg = 0; run(100, 2, 30, 30);
        mode_chg = 1; run(3, 2, 30, 30);
        mode_chg = 0; run(300, 2, 30, 30);
        run(1000, 2, 50, 50);
        summary();
    end
endmodule